// File: doc/BRIEF.md
# Interval Timer with Limit Compare

This block is a memory-mapped interval timer with a 32-bit word port and a single level interrupt. A prescaler turns the system clock into count ticks, one every `TICK_DIV` cycles, so that the tick period can be set to a fixed time (for example 500 ns) at any clock frequency. On each tick a 22-bit count advances. The count is presented in bits 30..9 of a 32-bit word, so the visible value rises by 0x200 per tick.

Software programs a limit. When the count equals a nonzero limit on a tick, the count reloads to zero on that tick. The same tick sets a sticky reached flag, which also drives the interrupt. A limit of zero makes the counter run free; it then wraps through its full range and never signals. Reading the limit acknowledges the interrupt. Two write addresses load the limit: one restarts the count and the prescaler, and the other leaves the count running.

Top module: `ivl_timer`

## Requirements
- R1: The counter word returns the count in bits 30..9 with bits 8..0 zero. With no match the count grows by one every `TICK_DIV` clock cycles. The prescaler phase starts from zero at reset and at every restarting limit write.
- R2: In a counter read (byte address 0x4), bit 31 returns the reached flag. The `irq` output always equals that flag.
- R3: With a nonzero limit, a tick that finds the count equal to the limit's bits 30..9 reloads the count to zero and sets the reached flag and `irq`. They stay set until the limit is read or rewritten at address 0x0.
- R4: With a limit of zero the count runs free, wrapping from 0x7FFFFE00 to zero, and the reached flag is never set.
- R5: A full-word read at byte address 0x0 returns the limit masked to bits 30..9 and clears the reached flag and `irq` at that clock edge.
- R6: A full-word write at byte address 0x0 stores write data bits 30..9 as the limit, clears the count, the reached flag, `irq` and the prescaler phase.
- R7: A full-word write at byte address 0x8 stores write data bits 30..9 as the limit and leaves the count, the prescaler phase and the reached flag untouched.
- R8: Writes at 0x4, 0xC and 0x10 have no effect. Any access whose byte enables are not all ones (`bus_be` != 4'hF) has no effect and reads as zero.
- R9: Reads at 0x8, 0xC, 0x10, unmapped word addresses and addresses with nonzero bits 1..0 return zero.
- R10: After reset the limit, the count and the reached flag are zero, and `irq` is low.
- R11: If a limit read and a matching tick fall in the same cycle, the reached flag and `irq` end up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address in the same cycle |
| irq | output | 1 | Level interrupt, high while the reached flag is set |

## Verification
The assertions assume that every bus input has a known value in each cycle after reset. They also assume that a read strobe held for N cycles counts as N reads, each one acknowledging. The stimulus sets all inputs before reset is released and changes them only on the falling clock edge. A peek read raises and drops `bus_sel` inside one low clock phase, so it never meets a rising edge. A read that must acknowledge holds the strobe across exactly one rising edge. The bench builds the design with a prescale of three, so tick phases, reload points and collisions can be placed on exact cycles.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CNT_LSB = 9;
    localparam int unsigned CNT_MSB = 30;
    localparam int unsigned CNT_W   = CNT_MSB - CNT_LSB + 1;

    typedef enum logic [2:0] {
        RS_LIMIT      = 3'd0,
        RS_COUNT      = 3'd1,
        RS_LIMIT_KEEP = 3'd2,
        RS_STATUS     = 3'd3,
        RS_MODE       = 3'd4,
        RS_NONE       = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     rd_ok;
        logic     rd_lim;
        logic     wr_lim_rst;
        logic     wr_lim_keep;
        reg_sel_e rsel;
    } acc_s;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             reached;
    } tmr_state_s;

endpackage

// File: rtl/ivl_tick_gen.sv
module ivl_tick_gen #(
    parameter int unsigned TICK_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_every
            logic unused_tick_in;
            assign unused_tick_in = clk ^ rst_n ^ restart;
            assign tick = 1'b1;
        end else begin : g_div
            logic [PW-1:0] pre_d, pre_q;

            assign tick = (pre_q == PW'(TICK_DIV - 1));

            always_comb begin
                pre_d = pre_q + 1'b1;
                if (tick)    pre_d = '0;
                if (restart) pre_d = '0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end
        end
    endgenerate
endmodule

// File: rtl/ivl_addr_dec.sv
module ivl_addr_dec
    import ivl_timer_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output acc_s              acc
);
    localparam int unsigned IW = ADDR_W - 2;

    logic          ok;
    logic [IW-1:0] idx;

    assign ok  = sel && (be == 4'hF) && (addr[1:0] == 2'b00);
    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        acc             = '0;
        acc.rsel        = RS_NONE;
        case (idx)
            IW'(0): acc.rsel = RS_LIMIT;
            IW'(1): acc.rsel = RS_COUNT;
            IW'(2): acc.rsel = RS_LIMIT_KEEP;
            IW'(3): acc.rsel = RS_STATUS;
            IW'(4): acc.rsel = RS_MODE;
            default: acc.rsel = RS_NONE;
        endcase
        acc.rd_ok       = ok && !we;
        acc.rd_lim      = ok && !we && (acc.rsel == RS_LIMIT);
        acc.wr_lim_rst  = ok &&  we && (acc.rsel == RS_LIMIT);
        acc.wr_lim_keep = ok &&  we && (acc.rsel == RS_LIMIT_KEEP);
    end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int unsigned TICK_DIV = 25,
    parameter int unsigned ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    acc_s       acc;
    logic       tick;
    logic       match;
    tmr_state_s st_d, st_q;
    logic       unused_wbits;

    assign unused_wbits = ^{bus_wdata[31], bus_wdata[CNT_LSB-1:0]};

    ivl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .be   (bus_be),
        .acc  (acc)
    );

    ivl_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (acc.wr_lim_rst),
        .tick    (tick)
    );

    assign match = tick && (st_q.lim != '0) && (st_q.cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (acc.rd_lim) st_d.reached = 1'b0;
        if (tick)       st_d.cnt     = match ? '0 : st_q.cnt + 1'b1;
        if (match)      st_d.reached = 1'b1;
        if (acc.wr_lim_keep) st_d.lim = bus_wdata[CNT_MSB:CNT_LSB];
        if (acc.wr_lim_rst) begin
            st_d.lim     = bus_wdata[CNT_MSB:CNT_LSB];
            st_d.cnt     = '0;
            st_d.reached = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (acc.rd_ok) begin
            case (acc.rsel)
                RS_LIMIT: bus_rdata = {1'b0, st_q.lim, {CNT_LSB{1'b0}}};
                RS_COUNT: bus_rdata = {st_q.reached, st_q.cnt, {CNT_LSB{1'b0}}};
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = st_q.reached;
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
    parameter int unsigned CNT_W = 22
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             rd_lim,
    input logic             wr_lim_rst,
    input logic             wr_lim_keep,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim,
    input logic             irq,
    input logic [31:0]      rdata
);
    a_r1_lowzero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[8:0] == 9'd0);

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lim_rst && !((lim != '0) && (cnt == lim)))
        |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lim_rst) |=> $stable(cnt));

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lim_rst && (lim != '0) && (cnt == lim))
        |=> (cnt == '0) && irq);

    a_r4_no_free_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(lim) != '0));

    a_r5_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && !(tick && (lim != '0) && (cnt == lim))) |=> !irq);

    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lim_rst |=> (cnt == '0) && !irq);

    a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lim_keep && !wr_lim_rst && !tick) |=> $stable(cnt));
endmodule

bind ivl_timer ivl_timer_chk #(.CNT_W(ivl_timer_pkg::CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rd_lim      (acc.rd_lim),
    .wr_lim_rst  (acc.wr_lim_rst),
    .wr_lim_keep (acc.wr_lim_keep),
    .cnt         (st_q.cnt),
    .lim         (st_q.lim),
    .irq         (irq),
    .rdata       (bus_rdata)
);

// File: tb/sim_ivl_timer.sv
module sim_ivl_timer;
    localparam int CLK_PERIOD = 10;
    localparam int D  = 3;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = 4'hF;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int k = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivl_timer #(.TICK_DIV(D), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (k=%0d)", req, act, exp, k);
        end
    endtask

    task automatic step();
        @(negedge clk);
        k++;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = b;
        step();
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
        if (a == '0 && b == 4'hF) k = 0;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_ack(input logic [3:0] b, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_be = b;
        #1 d = bus_rdata;
        step();
        bus_sel = 1'b0; bus_be = 4'hF;
    endtask

    function automatic logic [31:0] cword(input int lim, input int kk);
        int t = kk / D;
        int c;
        logic r;
        if (lim == 0) begin c = t; r = 1'b0; end
        else begin c = t % (lim + 1); r = (t >= lim + 1); end
        return {r, c[21:0], 9'd0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        peek(5'h4, d); chk("R10 count", d, 32'h0);
        peek(5'h0, d); chk("R10 limit", d, 32'h0);
        chk("R10 irq", {31'd0, irq}, 32'h0);

        // R1, R4: free run after a zero limit
        wr(5'h0, 32'h0, 4'hF);
        for (int i = 0; i < 40; i++) begin
            peek(5'h4, d); chk("R1 free count", d, cword(0, k));
            chk("R4 no irq", {31'd0, irq}, 32'h0);
            step();
        end

        // R3, R2, R5: sweep of small limits, junk in masked bits
        for (int lim = 1; lim <= 5; lim++) begin
            wr(5'h0, (lim << 9) | 32'h800001FF, 4'hF);
            for (int i = 0; i < (lim + 1) * D + 3; i++) begin
                peek(5'h4, d); chk("R3/R2 count word", d, cword(lim, k));
                chk("R2 irq equals flag", {31'd0, irq}, {31'd0, d[31]});
                step();
            end
            rd_ack(4'hF, d); chk("R5 limit readback", d, lim << 9);
            chk("R5 irq cleared", {31'd0, irq}, 32'h0);
            peek(5'h4, d); chk("R5 flag cleared", {31'd0, d[31]}, 32'h0);
        end

        // R11: ack in the same cycle as a matching tick
        wr(5'h0, 32'd2 << 9, 4'hF);
        while (k < 3 * D - 1) step();
        rd_ack(4'hF, d); chk("R11 limit value", d, 32'd2 << 9);
        chk("R11 irq kept", {31'd0, irq}, 32'h1);
        peek(5'h4, d); chk("R11 count word", d, 32'h8000_0000);

        // R6: restarting write clears irq, count and prescaler phase
        wr(5'h0, 32'd4 << 9, 4'hF);
        chk("R6 irq cleared", {31'd0, irq}, 32'h0);
        peek(5'h4, d); chk("R6 count zero", d, 32'h0);
        repeat (D - 1) step();
        peek(5'h4, d); chk("R6 phase restart", d, 32'h0);
        step();
        peek(5'h4, d); chk("R6 first tick", d, 32'd1 << 9);

        // R7: limit update without restart
        wr(5'h0, 32'd10 << 9, 4'hF);
        while (k < 4 * D) step();
        wr(5'h8, (32'd6 << 9) | 32'h1FF, 4'hF);
        peek(5'h4, d); chk("R7 count kept", d, 32'd4 << 9);
        peek(5'h0, d); chk("R7 new limit", d, 32'd6 << 9);
        while (k < 7 * D - 1) step();
        peek(5'h4, d); chk("R7 before match", d, 32'd6 << 9);
        step();
        peek(5'h4, d); chk("R7 match on new limit", d, 32'h8000_0000);

        // R8: ignored writes and partial accesses
        wr(5'h0, 32'd3 << 9, 4'hF);
        wr(5'h4, 32'h7FFF_FFFF, 4'hF);
        wr(5'hC, 32'h1, 4'hF);
        wr(5'h10, 32'hF, 4'hF);
        wr(5'h0, 32'd1 << 9, 4'h3);
        peek(5'h4, d); chk("R8 count unaffected", d, cword(3, k));
        rd_ack(4'h7, d); chk("R8 partial read zero", d, 32'h0);
        while (k < 12) step();
        peek(5'h4, d); chk("R8 match on kept limit", d, cword(3, k));
        rd_ack(4'h7, d); chk("R8 partial read no ack", {31'd0, irq}, 32'h1);
        peek(5'h0, d); chk("R8 limit unchanged", d, 32'd3 << 9);

        // R9: reads returning zero
        peek(5'h8, d);  chk("R9 read 0x8", d, 32'h0);
        peek(5'hC, d);  chk("R9 read 0xC", d, 32'h0);
        peek(5'h10, d); chk("R9 read 0x10", d, 32'h0);
        peek(5'h14, d); chk("R9 read 0x14", d, 32'h0);
        peek(5'h1C, d); chk("R9 read 0x1C", d, 32'h0);
        peek(5'h2, d);  chk("R9 misaligned", d, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule